// File: doc/BRIEF.md
# Filtered Input Event Detector

This block watches a group of asynchronous input pins and raises a sticky flag per pin when a selected event occurs. One shared 3-bit code chooses the event: a falling edge, a rising edge, either edge, a low level or a high level. The three codes above the last level mode are reserved and never produce a flag. Each pin first passes through a two-stage synchroniser. It can then pass through a glitch filter that samples either on every peripheral clock or only on a slow-clock tick. The slow-clock divider sits outside the block; it supplies a one-cycle tick.

Software or a neighbouring interrupt stage reads the flags and clears them one pin at a time with a clear strobe. None of the inputs carry a data stream, so every pin is a plain level or a plain strobe. There is no valid/ready handshake and no back-pressure. The filter enable, the filter clock select and the event code apply to all pins of the group. Each pin has its own synchroniser, its own filter, its own edge history and its own flag.

Top module: `pin_event_detector`

## Requirements
- R1: Edge codes: code 0 flags a falling edge only, code 1 a rising edge only, and code 2 either edge. The edge is taken between the current filtered level and the level registered one cycle earlier.
- R2: Level codes: code 3 flags while the filtered level is 0, and code 4 flags while it is 1.
- R3: Codes 5, 6 and 7 never set a flag, whatever the pin does.
- R4: With the filter enable low, the synchronised level goes straight to the detector, so a pin pulse one clock wide is seen. For an unfiltered step, the flag appears after the third rising clock edge.
- R5: With the filter enabled and the clock select low, the filter samples every clock. It passes a new level only after two consecutive samples agree. A one-cycle pulse is rejected and a three-cycle pulse is passed.
- R6: With the filter enabled and the clock select high, the filter samples only on cycles where the slow tick is high. A pulse shorter than one tick period is rejected, and a pulse spanning three ticks is passed.
- R7: A flag stays set until its clear strobe is high at a clock edge. Clear takes priority over a new event in the same cycle. After a clear in an edge mode, the flag stays low while no new edge arrives.
- R8: In a level mode, if the level still holds, a cleared flag is set again on the clock edge that follows the clear.
- R9: In the cycle where the event code differs from the code of the previous cycle, no event is flagged. A level change that coincides with a code change is therefore never reported as an edge.
- R10: While reset is asserted, all flags are 0.
- R11: Pins are independent. An event on one pin sets only that pin's flag, and a clear on one pin affects only that pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | LINES | Raw asynchronous pin levels |
| filt_en_i | input | 1 | Glitch filter enable (1 = filter) |
| filt_slow_i | input | 1 | Filter sample source: 0 every clock, 1 slow tick |
| slow_tick_i | input | 1 | One-cycle pulse from the external slow-clock divider |
| evt_sel_i | input | 3 | Event code: 0 fall, 1 rise, 2 both, 3 low, 4 high, 5-7 none |
| clr_i | input | LINES | Per-pin flag clear strobe |
| evt_flag_o | output | LINES | Per-pin sticky event flags |

## Verification
The bench targets four corner cases:
- A pulse exactly one clock wide. A filter that sampled too eagerly would let it through, and a pass-through path that was not truly transparent would lose it.
- A code change landing in the same cycle as a level change. A detector without history suppression would report a spurious edge there.
- A clear given while a level condition still holds. A design that let the event win over the clear would never show the flag low. A design that failed to re-arm would never set the flag again.
- Steps, pulses and steady levels under the reserved codes. A design that decoded those codes loosely would raise a flag.

// File: rtl/evtdet_pkg.sv
package evtdet_pkg;

  typedef enum logic [2:0] {
    EV_FALL = 3'd0,
    EV_RISE = 3'd1,
    EV_BOTH = 3'd2,
    EV_LOW  = 3'd3,
    EV_HIGH = 3'd4
  } evt_code_e;

  localparam int EVT_CODE_W = 3;

  // code value loaded into the history register at reset; reserved, never decodes
  localparam logic [EVT_CODE_W-1:0] EVT_CODE_IDLE = 3'd7;

endpackage

// File: rtl/evtdet_sync.sv
module evtdet_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/evtdet_glitch_filter.sv
module evtdet_glitch_filter #(
  parameter int HOLD_SAMPLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic filt_en,
  input  logic slow_sel,
  input  logic slow_tick,
  output logic dout
);

  localparam int CW = (HOLD_SAMPLES > 2) ? $clog2(HOLD_SAMPLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(HOLD_SAMPLES - 1);

  logic          stable_q;
  logic [CW-1:0] run_q;
  logic          sample;

  // sample strobe: every clock, or only on the divided slow-clock tick
  assign sample = slow_sel ? slow_tick : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stable_q <= 1'b0;
      run_q    <= '0;
    end else if (!filt_en) begin
      // follow the input so enabling the filter later causes no jump
      stable_q <= din;
      run_q    <= '0;
    end else if (sample) begin
      if (din == stable_q) begin
        run_q <= '0;
      end else if (run_q == LAST) begin
        stable_q <= din;
        run_q    <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  assign dout = filt_en ? stable_q : din;

endmodule

// File: rtl/evtdet_detector.sv
module evtdet_detector
  import evtdet_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  level,
  input  logic [EVT_CODE_W-1:0] evt_sel,
  input  logic                  clr,
  output logic                  flag
);

  logic                  prev_q;
  logic [EVT_CODE_W-1:0] sel_q;
  logic                  flag_q;
  logic                  code_chg;
  logic                  hit_raw;
  logic                  hit;

  assign code_chg = (evt_sel != sel_q);

  always_comb begin
    case (evt_sel)
      EV_FALL: hit_raw =  prev_q & ~level;
      EV_RISE: hit_raw = ~prev_q &  level;
      EV_BOTH: hit_raw =  prev_q ^  level;
      EV_LOW:  hit_raw = ~level;
      EV_HIGH: hit_raw =  level;
      default: hit_raw = 1'b0;
    endcase
  end

  // a fresh code voids the edge history for this cycle
  assign hit = hit_raw & ~code_chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      sel_q  <= EVT_CODE_IDLE;
      flag_q <= 1'b0;
    end else begin
      prev_q <= level;
      sel_q  <= evt_sel;
      if (clr) flag_q <= 1'b0;
      else     flag_q <= flag_q | hit;
    end
  end

  assign flag = flag_q;

endmodule

// File: rtl/pin_event_detector.sv
module pin_event_detector
  import evtdet_pkg::*;
#(
  parameter int LINES        = 4,
  parameter int SYNC_STAGES  = 2,
  parameter int HOLD_SAMPLES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [LINES-1:0]      pin_i,
  input  logic                  filt_en_i,
  input  logic                  filt_slow_i,
  input  logic                  slow_tick_i,
  input  logic [EVT_CODE_W-1:0] evt_sel_i,
  input  logic [LINES-1:0]      clr_i,
  output logic [LINES-1:0]      evt_flag_o
);

  logic [LINES-1:0] sync_lvl;
  logic [LINES-1:0] filt_lvl;

  generate
    for (genvar i = 0; i < LINES; i++) begin : g_line
      evtdet_sync #(
        .STAGES (SYNC_STAGES)
      ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pin_i[i]),
        .dout  (sync_lvl[i])
      );

      evtdet_glitch_filter #(
        .HOLD_SAMPLES (HOLD_SAMPLES)
      ) u_filt (
        .clk       (clk),
        .rst_n     (rst_n),
        .din       (sync_lvl[i]),
        .filt_en   (filt_en_i),
        .slow_sel  (filt_slow_i),
        .slow_tick (slow_tick_i),
        .dout      (filt_lvl[i])
      );

      evtdet_detector u_det (
        .clk     (clk),
        .rst_n   (rst_n),
        .level   (filt_lvl[i]),
        .evt_sel (evt_sel_i),
        .clr     (clr_i[i]),
        .flag    (evt_flag_o[i])
      );
    end
  endgenerate

endmodule

// File: rtl/pin_event_detector_chk.sv
module pin_event_detector_chk #(
  parameter int LINES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       evt_sel_i,
  input logic [LINES-1:0] clr_i,
  input logic [LINES-1:0] evt_flag_o
);

  generate
    for (genvar i = 0; i < LINES; i++) begin : g_chk
      // R3: a flag may only rise after a cycle with a defined code
      assert_rsvd_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_flag_o[i] && !$past(evt_flag_o[i])) |-> ($past(evt_sel_i) <= 3'd4));

      // R7: a set flag holds unless cleared
      assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(evt_flag_o[i]) && !$past(clr_i[i])) |-> evt_flag_o[i]);

      // R7: clear wins over any event in the same cycle
      assert_clear_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr_i[i]) |-> !evt_flag_o[i]);

      // R9: no flag rises from a cycle in which the code just changed
      assert_code_change_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_flag_o[i] && !$past(evt_flag_o[i])) |-> ($past(evt_sel_i) == $past(evt_sel_i, 2)));
    end
  endgenerate

endmodule

bind pin_event_detector pin_event_detector_chk #(.LINES(LINES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .evt_sel_i  (evt_sel_i),
  .clr_i      (clr_i),
  .evt_flag_o (evt_flag_o)
);

// File: tb/pin_event_detector_tb.sv
module pin_event_detector_tb;

  localparam int LINES = 4;
  localparam int NV    = 16;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [LINES-1:0] pin_i;
  logic             filt_en_i;
  logic             filt_slow_i;
  logic             slow_tick_i;
  logic [2:0]       evt_sel_i;
  logic [LINES-1:0] clr_i;
  logic [LINES-1:0] evt_flag_o;

  int  checks   = 0;
  int  failures = 0;
  bit  done     = 1'b0;
  int  tick_cnt = 0;

  always #4 clk = ~clk;

  pin_event_detector #(.LINES(LINES)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .pin_i       (pin_i),
    .filt_en_i   (filt_en_i),
    .filt_slow_i (filt_slow_i),
    .slow_tick_i (slow_tick_i),
    .evt_sel_i   (evt_sel_i),
    .clr_i       (clr_i),
    .evt_flag_o  (evt_flag_o)
  );

  // slow tick: one cycle high out of every four, driven off the active edge
  always @(negedge clk) begin
    tick_cnt    <= (tick_cnt + 1) % 4;
    slow_tick_i <= (tick_cnt == 3);
  end

  // fields: sel[11:9] fen[8] slow[7] base[6] len[5:1] (0 = step) exp[0]
  localparam logic [11:0] VEC [NV] = '{
    {3'd1, 1'b0, 1'b0, 1'b0, 5'd0,  1'b1},  // R1 rise sees step up
    {3'd1, 1'b0, 1'b0, 1'b1, 5'd0,  1'b0},  // R1 rise ignores step down
    {3'd0, 1'b0, 1'b0, 1'b1, 5'd0,  1'b1},  // R1 fall sees step down
    {3'd0, 1'b0, 1'b0, 1'b0, 5'd0,  1'b0},  // R1 fall ignores step up
    {3'd2, 1'b0, 1'b0, 1'b0, 5'd0,  1'b1},  // R1 both, up
    {3'd2, 1'b0, 1'b0, 1'b1, 5'd0,  1'b1},  // R1 both, down
    {3'd3, 1'b0, 1'b0, 1'b1, 5'd0,  1'b1},  // R2 low level
    {3'd4, 1'b0, 1'b0, 1'b0, 5'd0,  1'b1},  // R2 high level
    {3'd5, 1'b0, 1'b0, 1'b0, 5'd0,  1'b0},  // R3 code 5
    {3'd6, 1'b0, 1'b0, 1'b1, 5'd0,  1'b0},  // R3 code 6
    {3'd7, 1'b0, 1'b0, 1'b0, 5'd3,  1'b0},  // R3 code 7
    {3'd1, 1'b0, 1'b0, 1'b0, 5'd1,  1'b1},  // R4 unfiltered 1-cycle pulse
    {3'd1, 1'b1, 1'b0, 1'b0, 5'd1,  1'b0},  // R5 1-cycle pulse rejected
    {3'd1, 1'b1, 1'b0, 1'b0, 5'd3,  1'b1},  // R5 3-cycle pulse passed
    {3'd1, 1'b1, 1'b1, 1'b0, 5'd3,  1'b0},  // R6 sub-tick pulse rejected
    {3'd1, 1'b1, 1'b1, 1'b0, 5'd12, 1'b1}   // R6 three-tick pulse passed
  };
  localparam string VTAG [NV] = '{"R1","R1","R1","R1","R1","R1","R2","R2",
                                  "R3","R3","R3","R4","R5","R5","R6","R6"};

  task automatic check(input string tag, input logic [LINES-1:0] act,
                       input logic [LINES-1:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic clear_all();
    @(negedge clk) clr_i = '1;
    @(negedge clk) clr_i = '0;
  endtask

  initial begin
    #1_200_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual hung, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n       = 1'b0;
    pin_i       = '0;
    filt_en_i   = 1'b0;
    filt_slow_i = 1'b0;
    evt_sel_i   = 3'd4;
    clr_i       = '0;
    slow_tick_i = 1'b0;
    pin_i[1]    = 1'b1;
    cycles(4);
    check("R10", evt_flag_o, '0, "flags during reset");
    @(negedge clk) rst_n = 1'b1;
    pin_i = '0;
    evt_sel_i = 3'd1;
    cycles(6);
    clear_all();

    // vector table
    for (int v = 0; v < NV; v++) begin
      logic [11:0] vv;
      vv = VEC[v];
      @(negedge clk);
      evt_sel_i   = vv[11:9];
      filt_en_i   = vv[8];
      filt_slow_i = vv[7];
      pin_i       = '0;
      pin_i[0]    = vv[6];
      cycles(16);
      clear_all();
      cycles(2);
      pin_i[0] = ~vv[6];
      if (vv[5:1] != 5'd0) begin
        cycles(int'(vv[5:1]));
        pin_i[0] = vv[6];
      end
      cycles(24);
      check(VTAG[v], evt_flag_o[0], vv[0], $sformatf("vector %0d flag", v));
    end

    // R4: unfiltered step latency, flag after the third rising edge
    filt_en_i = 1'b0; evt_sel_i = 3'd1; pin_i = '0;
    cycles(8); clear_all();
    pin_i[0] = 1'b1;
    cycles(2);
    check("R4", evt_flag_o[0], 1'b0, "flag two edges after step");
    cycles(1);
    check("R4", evt_flag_o[0], 1'b1, "flag three edges after step");

    // R7: sticky, then cleared in edge mode stays low
    cycles(40);
    check("R7", evt_flag_o[0], 1'b1, "flag still held");
    clear_all();
    cycles(10);
    check("R7", evt_flag_o[0], 1'b0, "edge flag stays cleared");

    // R8: level re-assertion on the edge after the clear
    evt_sel_i = 3'd4;
    cycles(6);
    check("R8", evt_flag_o[0], 1'b1, "high level flagged");
    @(negedge clk) clr_i[0] = 1'b1;
    @(negedge clk) clr_i[0] = 1'b0;
    check("R8", evt_flag_o[0], 1'b0, "flag low right after clear");
    @(negedge clk);
    check("R8", evt_flag_o[0], 1'b1, "flag back one edge later");

    // R9: code change coinciding with a level change
    evt_sel_i = 3'd0; pin_i = '0;
    cycles(8); clear_all(); cycles(2);
    @(negedge clk) pin_i[0] = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk) evt_sel_i = 3'd1;
    cycles(10);
    check("R9", evt_flag_o[0], 1'b0, "no edge on code change");

    // R11: one pin's event and clear stay on that pin
    evt_sel_i = 3'd1; pin_i = '0;
    cycles(8); clear_all(); cycles(2);
    pin_i[2] = 1'b1;
    cycles(10);
    check("R11", evt_flag_o, 4'b0100, "only pin 2 flagged");
    pin_i[3] = 1'b1;
    cycles(10);
    @(negedge clk) clr_i = 4'b0100;
    @(negedge clk) clr_i = '0;
    check("R11", evt_flag_o, 4'b1000, "clear touches pin 2 only");

    // R10: reset clears held flags
    @(negedge clk) rst_n = 1'b0;
    cycles(1);
    check("R10", evt_flag_o, '0, "flags after reset asserted");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  end

endmodule